// File: doc/BRIEF.md
# Bit-Serial SDLC Frame Receiver with Complete Check-Sequence Capture

This block receives a synchronous serial bit stream, one bit per cycle in which the bit strobe is high, and turns it into octets in a four-entry receive queue. It searches the stream for the 01111110 flag pattern, removes the zero bits that a transmitter inserts after five ones, packs the remaining bits least-significant first into octets, and tags the last octet of each frame as end-of-frame. A run of seven ones inside a frame is treated as an abort.

Its main property concerns the frame check sequence. The block accepts the two check octets as ordinary data and does not verify them. In SDLC mode the last two bits of the frame are still in a two-bit holding stage when the closing flag is recognised. The block moves them into the final octet, so the whole check sequence reaches the queue and software can read it or send it again. No enable bit controls this. In generic synchronous mode the block keeps the older behaviour. The final octet is written as soon as the flag is seen, and its last two bits are lost.

A shared flag may close one frame and open the next. Entries are read with a pop strobe, and the block pulses an overrun output when it must write to a full queue.

Top module: `sdlc_rx_capture`

## Requirements
- R1: While reset is asserted, and after it is released, `rd_valid` and `overrun` are low.
- R2: The flag 0x7E is recognised in the raw stream. Flags that have no data bits between them write no entry.
- R3: Inside a frame, a 0 that follows five consecutive 1s in the raw stream is removed before octets are assembled.
- R4: Data bits are packed least-significant bit first. Every complete octet that is not the last of its frame is queued with end-of-frame = 0 and abort = 0.
- R5: With `sdlc_mode` = 1, the closing flag writes the final octet with all eight bits, including the two that arrived last, and sets end-of-frame = 1.
- R6: With `sdlc_mode` = 0, the closing flag writes the final octet with only its first six received bits in data[5:0] and zeros in data[7:6], and sets end-of-frame = 1.
- R7: A single flag can close one frame and open the next. Both frames are delivered completely.
- R8: Seven consecutive 1s in a frame in which at least one bit came after the flag write one entry with data 0x00, abort = 1 and end-of-frame = 0. The receiver then ignores data until the next flag.
- R9: Seven 1s that directly follow a flag (a line marking idle) write no entry.
- R10: The queue holds 4 entries and returns them in arrival order. `rd_valid` is high when it is not empty, and a cycle with `rd_en` high removes the head entry.
- R11: A write to a full queue is dropped, and `overrun` goes high for one cycle.
- R12: `rx_bit` is sampled only in cycles where `bit_en` is high. Its value in other cycles has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | Strobe marking a cycle that carries a received bit |
| rx_bit | input | 1 | Serial receive data |
| sdlc_mode | input | 1 | 1 selects SDLC tail handling, 0 selects generic synchronous |
| rd_en | input | 1 | Removes the head entry of the queue |
| rd_valid | output | 1 | Queue holds at least one entry |
| rd_data | output | 8 | Octet at the head of the queue |
| rd_eof | output | 1 | Head entry is the last octet of a frame |
| rd_abort | output | 1 | Head entry marks an aborted frame |
| overrun | output | 1 | One-cycle pulse when a write finds the queue full |

## Verification
The hardest situation to reach is the closing flag arriving while the final two data bits are still in the holding stage behind a seven-bit flag window. Reaching it needs a frame whose bit count after stuffing is an exact multiple of eight. The stimulus builds frames octet by octet and inserts the stuffed zeros itself. Several frames carry runs of ones that cross octet boundaries, so that the deleted zeros shift where octets fall in the raw stream. The same octet patterns are sent in both modes, which shows that only the last octet of a frame changes between them.

// File: rtl/sdlc_rx_pkg.sv
package sdlc_rx_pkg;
  localparam int CHAR_W = 8;
  localparam logic [CHAR_W-1:0] FLAG_PAT = 8'h7E;

  typedef struct packed {
    logic              abort;
    logic              eof;
    logic [CHAR_W-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/sdlc_rx_framer.sv
// Flag hunt, abort detection and zero deletion on the raw bit stream.
module sdlc_rx_framer
  import sdlc_rx_pkg::*;
#(
  parameter int STUFF_RUN = 5,
  parameter int ABORT_RUN = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic rx_bit,
  output logic out_vld,
  output logic out_bit,
  output logic flag_evt,
  output logic abort_evt
);
  localparam int WIN_W = CHAR_W - 1;
  localparam int CNT_W = $clog2(WIN_W + 1);
  localparam int RUN_W = $clog2(ABORT_RUN + 1);
  localparam logic [CNT_W-1:0] WIN_FULL  = CNT_W'(WIN_W);
  localparam logic [RUN_W-1:0] RUN_SAT   = RUN_W'(ABORT_RUN);
  localparam logic [RUN_W-1:0] STUFF_LIM = RUN_W'(STUFF_RUN);
  localparam logic [RUN_W-1:0] ABORT_LIM = RUN_W'(ABORT_RUN - 1);

  logic [WIN_W-1:0]  win_q, win_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              frm_q, frm_d;
  logic [RUN_W-1:0]  raw_q, raw_d;
  logic [RUN_W-1:0]  stf_q, stf_d;
  logic [CHAR_W-1:0] win_shift;
  logic              win_full, flag_hit, abort_hit, exit_bit, stuffed;

  // decode of the seven held bits plus the arriving one
  always_comb begin
    win_shift = {rx_bit, win_q};
    win_full  = (cnt_q == WIN_FULL);
    flag_hit  = bit_en && win_full && (win_shift == FLAG_PAT);
    abort_hit = bit_en && frm_q && rx_bit && (raw_q >= ABORT_LIM);
    exit_bit  = bit_en && frm_q && win_full && !flag_hit && !abort_hit;
    stuffed   = !win_q[0] && (stf_q == STUFF_LIM);
    out_vld   = exit_bit && !stuffed;
    out_bit   = win_q[0];
    flag_evt  = flag_hit;
    abort_evt = abort_hit && win_full;
  end

  always_comb begin
    win_d = win_q;
    cnt_d = cnt_q;
    frm_d = frm_q;
    raw_d = raw_q;
    stf_d = stf_q;
    if (bit_en) begin
      win_d = win_shift[CHAR_W-1:1];
      raw_d = rx_bit ? ((raw_q == RUN_SAT) ? raw_q : raw_q + 1'b1) : '0;
      if (flag_hit) begin
        cnt_d = '0;
        frm_d = 1'b1;
        stf_d = '0;
      end else begin
        cnt_d = win_full ? cnt_q : cnt_q + 1'b1;
        if (abort_hit) begin
          frm_d = 1'b0;
          stf_d = '0;
        end else if (exit_bit) begin
          stf_d = win_q[0] ? ((stf_q == RUN_SAT) ? stf_q : stf_q + 1'b1) : '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      cnt_q <= '0;
      frm_q <= 1'b0;
      raw_q <= '0;
      stf_q <= '0;
    end else if (bit_en) begin
      win_q <= win_d;
      cnt_q <= cnt_d;
      frm_q <= frm_d;
      raw_q <= raw_d;
      stf_q <= stf_d;
    end
  end

  // a flag always ends in a zero on the line
  assert_flag_ends_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flag_evt |-> !rx_bit);
  // an abort event is only raised on a strobed one
  assert_abort_on_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |-> (bit_en && rx_bit));
endmodule

// File: rtl/sdlc_rx_assembler.sv
// Two-bit holding stage, octet packing and closing-flag tail handling.
module sdlc_rx_assembler
  import sdlc_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sdlc_mode,
  input  logic      in_vld,
  input  logic      in_bit,
  input  logic      flag_evt,
  input  logic      abort_evt,
  output logic      wr_en,
  output rx_entry_t wr_entry
);
  localparam int TAIL = 2;
  localparam int BC_W = $clog2(CHAR_W);
  localparam int DC_W = $clog2(TAIL + 1);
  localparam logic [BC_W-1:0] BC_LAST   = BC_W'(CHAR_W - 1);
  localparam logic [DC_W-1:0] TAIL_FULL = DC_W'(TAIL);

  logic [TAIL-1:0]   dly_q, dly_d;
  logic [DC_W-1:0]   dcnt_q, dcnt_d;
  logic [CHAR_W-1:0] sh_q, sh_d;
  logic [BC_W-1:0]   bcnt_q, bcnt_d;
  logic              busy_q, busy_d;
  logic              step;

  assign step = flag_evt || abort_evt || in_vld;

  always_comb begin
    dly_d    = dly_q;
    dcnt_d   = dcnt_q;
    sh_d     = sh_q;
    bcnt_d   = bcnt_q;
    busy_d   = busy_q;
    wr_en    = 1'b0;
    wr_entry = '0;
    if (flag_evt || abort_evt) begin
      if (flag_evt && busy_q) begin
        wr_en        = 1'b1;
        wr_entry.eof = 1'b1;
        wr_entry.data = sdlc_mode ? {dly_q, sh_q[CHAR_W-1:TAIL]}
                                  : {{TAIL{1'b0}}, sh_q[CHAR_W-1:TAIL]};
      end else if (abort_evt) begin
        wr_en          = 1'b1;
        wr_entry.abort = 1'b1;
      end
      dly_d  = '0;
      dcnt_d = '0;
      sh_d   = '0;
      bcnt_d = '0;
      busy_d = 1'b0;
    end else if (in_vld) begin
      busy_d = 1'b1;
      dly_d  = {in_bit, dly_q[TAIL-1:1]};
      if (dcnt_q != TAIL_FULL) begin
        dcnt_d = dcnt_q + 1'b1;
      end else begin
        sh_d = {dly_q[0], sh_q[CHAR_W-1:1]};
        if (bcnt_q == BC_LAST) begin
          wr_en         = 1'b1;
          wr_entry.data = sh_d;
          bcnt_d        = '0;
        end else begin
          bcnt_d = bcnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q  <= '0;
      dcnt_q <= '0;
      sh_q   <= '0;
      bcnt_q <= '0;
      busy_q <= 1'b0;
    end else if (step) begin
      dly_q  <= dly_d;
      dcnt_q <= dcnt_d;
      sh_q   <= sh_d;
      bcnt_q <= bcnt_d;
      busy_q <= busy_d;
    end
  end

  // end-of-frame entries come only from a closing flag of the framer
  assert_eof_from_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_entry.eof) |-> flag_evt);
  // in generic mode the truncated tail leaves the two top bits clear
  assert_generic_tail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_entry.eof && !sdlc_mode) |-> (wr_entry.data[CHAR_W-1 -: TAIL] == '0));
  // a flag leaves the packing path empty for the next frame
  assert_clear_after_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_evt |=> (bcnt_q == '0 && dcnt_q == '0 && !busy_q));
endmodule

// File: rtl/sdlc_rx_fifo.sv
// Receive queue of tagged octets with overrun pulse.
module sdlc_rx_fifo
  import sdlc_rx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  rx_entry_t wr_entry,
  input  logic      rd_en,
  output logic      rd_valid,
  output rx_entry_t rd_entry,
  output logic      overrun
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(DEPTH);

  rx_entry_t       mem_q [DEPTH];
  logic [AW-1:0]   wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            ovr_q, ovr_d;
  logic            full, do_wr, do_rd;

  always_comb begin
    full     = (cnt_q == CNT_MAX);
    rd_valid = (cnt_q != '0);
    do_wr    = wr_en && !full;
    do_rd    = rd_en && rd_valid;
    rd_entry = mem_q[rp_q];
    wp_d     = do_wr ? ((wp_q == PTR_LAST) ? '0 : wp_q + 1'b1) : wp_q;
    rp_d     = do_rd ? ((rp_q == PTR_LAST) ? '0 : rp_q + 1'b1) : rp_q;
    cnt_d    = cnt_q + CW'(do_wr) - CW'(do_rd);
    ovr_d    = wr_en && full;
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem_q[wp_q] <= wr_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      ovr_q <= ovr_d;
    end
  end

  assign overrun = ovr_q;

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);
  // a dropped write leaves the queue still holding data
  assert_overrun_nonempty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> rd_valid);
endmodule

// File: rtl/sdlc_rx_capture.sv
module sdlc_rx_capture
  import sdlc_rx_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int STUFF_RUN  = 5,
  parameter int ABORT_RUN  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              rx_bit,
  input  logic              sdlc_mode,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [CHAR_W-1:0] rd_data,
  output logic              rd_eof,
  output logic              rd_abort,
  output logic              overrun
);
  logic [1:0] rst_sync_q;
  logic       rst_n_i;
  logic       f_vld, f_bit, f_flag, f_abort;
  logic       a_wr;
  rx_entry_t  a_entry, q_head;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  sdlc_rx_framer #(.STUFF_RUN(STUFF_RUN), .ABORT_RUN(ABORT_RUN)) i_framer (
    .clk(clk), .rst_n(rst_n_i), .bit_en(bit_en), .rx_bit(rx_bit),
    .out_vld(f_vld), .out_bit(f_bit), .flag_evt(f_flag), .abort_evt(f_abort)
  );

  sdlc_rx_assembler i_assembler (
    .clk(clk), .rst_n(rst_n_i), .sdlc_mode(sdlc_mode),
    .in_vld(f_vld), .in_bit(f_bit), .flag_evt(f_flag), .abort_evt(f_abort),
    .wr_en(a_wr), .wr_entry(a_entry)
  );

  sdlc_rx_fifo #(.DEPTH(FIFO_DEPTH)) i_fifo (
    .clk(clk), .rst_n(rst_n_i), .wr_en(a_wr), .wr_entry(a_entry),
    .rd_en(rd_en), .rd_valid(rd_valid), .rd_entry(q_head), .overrun(overrun)
  );

  assign rd_data  = q_head.data;
  assign rd_eof   = q_head.eof;
  assign rd_abort = q_head.abort;
endmodule

// File: tb/test_sdlc_rx_capture.sv
module test_sdlc_rx_capture;
  logic       clk = 1'b0;
  logic       rst_n, bit_en, rx_bit, sdlc_mode, rd_en;
  logic       rd_valid, rd_eof, rd_abort, overrun;
  logic [7:0] rd_data;
  int n_cmp = 0;
  int n_bad = 0;
  int ovr_seen = 0;
  int ones_run = 0;

  always #4 clk = ~clk;

  sdlc_rx_capture i_sdlc_rx_capture (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .sdlc_mode(sdlc_mode), .rd_en(rd_en), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_eof(rd_eof), .rd_abort(rd_abort), .overrun(overrun)
  );

  always @(negedge clk) if (overrun === 1'b1) ovr_seen++;

  // {sdlc mode, length, octet0 .. octet3}; the last two octets of each frame act as its check sequence
  localparam logic [35:0] VEC [6] = '{
    {1'b1, 3'd3, 8'hA5, 8'h3C, 8'h81, 8'h00},
    {1'b1, 3'd4, 8'hFF, 8'h7E, 8'h1F, 8'hF8},  // R3: runs of ones force deleted zeros
    {1'b0, 3'd3, 8'h12, 8'h34, 8'hFF, 8'h00},
    {1'b0, 3'd2, 8'hC3, 8'h7E, 8'h00, 8'h00},
    {1'b1, 3'd1, 8'hC0, 8'h00, 8'h00, 8'h00},
    {1'b0, 3'd1, 8'hC0, 8'h00, 8'h00, 8'h00}
  };

  task automatic cmp(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // R12: the line carries the inverted bit while the strobe is low
  task automatic send_raw(input logic b);
    @(negedge clk);
    rx_bit = b;
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    rx_bit = ~b;
  endtask

  task automatic send_flag();
    for (int i = 0; i < 8; i++) send_raw(1'b0 ^ (i != 0 && i != 7));
    ones_run = 0;
  endtask

  task automatic send_octet(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      send_raw(v[i]);
      ones_run = v[i] ? ones_run + 1 : 0;
      if (ones_run == 5) begin
        send_raw(1'b0);
        ones_run = 0;
      end
    end
  endtask

  task automatic expect_entry(input string tag, input logic [7:0] d, input logic eof, input logic ab);
    cmp({tag, " valid"}, {15'd0, rd_valid}, 16'd1);
    cmp(tag, {6'd0, rd_abort, rd_eof, rd_data}, {6'd0, ab, eof, d});
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic expect_empty(input string tag);
    cmp(tag, {15'd0, rd_valid}, 16'd0);
  endtask

  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; rx_bit = 1'b0; rd_en = 1'b0; sdlc_mode = 1'b1;
    repeat (3) @(negedge clk);
    cmp("R1 valid in reset", {15'd0, rd_valid}, 16'd0);
    cmp("R1 overrun in reset", {15'd0, overrun}, 16'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp("R1 valid after reset", {15'd0, rd_valid}, 16'd0);
    cmp("R1 overrun after reset", {15'd0, overrun}, 16'd0);

    // table walk: R4 middle octets, R5/R6 closing octet, R2 idle flags between frames
    for (int v = 0; v < 6; v++) begin
      logic       md;
      int         len;
      logic [7:0] ex;
      md = VEC[v][35];
      len = int'(VEC[v][34:32]);
      sdlc_mode = md;
      send_flag();
      for (int k = 0; k < len; k++) send_octet(VEC[v][31-8*k -: 8]);
      send_flag();
      for (int k = 0; k < len; k++) begin
        ex = VEC[v][31-8*k -: 8];
        if (k == len - 1) begin
          if (!md) ex = ex & 8'h3F;
          expect_entry($sformatf("%s vec%0d octet%0d", md ? "R5" : "R6", v, k), ex, 1'b1, 1'b0);
        end else begin
          expect_entry($sformatf("R4 R3 vec%0d octet%0d", v, k), ex, 1'b0, 1'b0);
        end
      end
      expect_empty($sformatf("R2 vec%0d no extra entry", v));
    end

    // R7: one flag shared between two frames
    sdlc_mode = 1'b1;
    send_flag();
    send_octet(8'hAA);
    send_octet(8'h55);
    send_flag();
    send_octet(8'h0F);
    send_flag();
    expect_entry("R7 first frame octet", 8'hAA, 1'b0, 1'b0);
    expect_entry("R7 first frame tail", 8'h55, 1'b1, 1'b0);
    expect_entry("R7 second frame tail", 8'h0F, 1'b1, 1'b0);
    expect_empty("R7 nothing more");

    // R8: abort after data, then ignored ones, then recovery on next flag
    send_flag();
    send_octet(8'h11);
    send_octet(8'h22);
    for (int i = 0; i < 7; i++) send_raw(1'b1);
    for (int i = 0; i < 3; i++) send_raw(1'b1);
    expect_entry("R8 octet before abort", 8'h11, 1'b0, 1'b0);
    expect_entry("R8 abort marker", 8'h00, 1'b0, 1'b1);
    expect_empty("R8 ones after abort ignored");
    send_flag();
    send_octet(8'h5A);
    send_flag();
    expect_entry("R8 recovery frame", 8'h5A, 1'b1, 1'b0);
    expect_empty("R8 recovery done");

    // R9: marking idle right after a flag
    send_flag();
    for (int i = 0; i < 10; i++) send_raw(1'b1);
    expect_empty("R9 idle ones silent");
    send_flag();
    send_flag();
    expect_empty("R9 R2 flags only");

    // R10 / R11: six octets into a four-entry queue
    ovr_seen = 0;
    send_flag();
    for (int k = 1; k <= 6; k++) send_octet(8'(k));
    send_flag();
    repeat (2) @(negedge clk);
    cmp("R11 overrun pulses", 16'(ovr_seen), 16'd2);
    for (int k = 1; k <= 4; k++)
      expect_entry($sformatf("R10 order octet%0d", k), 8'(k), 1'b0, 1'b0);
    expect_empty("R10 R11 dropped writes");
    cmp("R11 overrun low after", {15'd0, overrun}, 16'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule